// File: doc/BRIEF.md
# Variable-Width Chunk SPI Master

This block is an SPI master controlled through a small word-wide register interface. Software writes transmit words into a four-entry queue. Each word states how many bits it shifts, from 1 to 24, and carries a left-aligned payload. A single controller can therefore send 8-, 16- or 24-bit chunks without being reconfigured. The write address decides what happens to the chip select after the chunk. A word written to the hold address keeps the select asserted so that the next chunk continues the same frame. A word written to the data address releases the select once its chunk has finished.

Every received chunk is placed right-aligned into a four-entry receive queue. A read of the data address takes the oldest entry out. Control registers set the clock divider, the idle clock level, which clock edge launches data, which edge captures data, and the bit order in each direction. After every chunk the master inserts two idle SPI clock periods. A status register reports the queue levels and the queue flags. A level interrupt can be raised when the transmit queue is empty, when the engine is idle, or both.

Top module: `spi_vw_master`

## Requirements
- R1: After reset, the status register (offset 0x08) reads 0x0000_0280, with only the TX-empty and RX-empty flags set. At the same point, `spi_cs_n` is 1, `spi_sclk` is 0 and `irq` is 0.
- R2: The divider field is control-0 bits 31:20 and holds the value SPEED. During a chunk, `spi_sclk` changes level every SPEED+1 system clock cycles.
- R3: When control-0 bit 14 is set, bits 31:24 of a transmit word give the chunk length N, and the payload is left-aligned so that its first bit is bit 23. When bit 14 is clear, N is 8 and the payload sits in bits 23:16.
- R4: Received chunks are right-aligned, with bits above N reading as zero. A read of offset 0x20 returns the oldest entry and removes it from the queue. A read of 0x20 when the receive queue is empty returns 0.
- R5: `spi_cs_n` falls when a chunk starts. A word written to offset 0x30 keeps `spi_cs_n` low into the next chunk with no high cycle in between. A word written to offset 0x20 raises `spi_cs_n` when its chunk has finished.
- R6: One isolated chunk of N bits keeps the engine busy for exactly (2N+4)·(SPEED+1) cycles. This time includes two idle SPI clock periods after the chunk. Status bit 6 reads 1 for the whole of that interval.
- R7: Control-0 bit 7 sets the level of `spi_sclk` between chunks. Bit 8 selects the rising edge for launching data, and bit 10 selects the rising edge for capturing data; when either bit is 0, the falling edge is used. With `spi_miso` looped back to `spi_mosi`, every combination of these three bits returns the transmitted data.
- R8: Control-0 bit 6 selects most-significant-bit-first transmission, and control-1 bit 1 selects most-significant-bit-first capture. When a bit is clear, that direction works least-significant-bit first. Mixing the two settings reverses the bit order of the chunk.
- R9: In the status register, bits 31:24 hold the TX level and bits 23:16 hold the RX level. Bit 10 is TX full, bit 9 TX empty, bit 8 RX full and bit 7 RX empty. Each queue holds 4 entries, and a word written while the TX queue is full is dropped.
- R10: Writing 0 to control-1 (offset 0x04) and then 0x200 to control-0 (offset 0x00) empties both queues and clears the enable bit (control-0 bit 11). While bit 11 is clear, queued words do not start. Bit 9 of control-0 acts only at the moment of the write and always reads back as 0.
- R11: `irq` is high when control-1 bit 7 is set and the TX queue is empty. `irq` is also high when control-1 bit 6 is set and the engine is not busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe; needed only for the read that pops the data register |
| bus_addr | input | ADDR_W | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from bus_addr |
| spi_sclk | output | 1 | SPI clock |
| spi_mosi | output | 1 | Serial data out |
| spi_miso | input | 1 | Serial data in |
| spi_cs_n | output | 1 | Active-low chip select |
| irq | output | 1 | Level interrupt |

## Verification
The loopback tests are run with every polarity and edge setting, including launch and capture on the same edge. Each of those settings moves the first launched bit relative to the first capture, so a launch that is one edge off shows up as corrupted data. Chunks of 8, 16 and 24 bits are combined with both bit orders and with a mixed order. Only the mixed-order case can tell a reversed shift direction apart from a reversed capture. A 24-bit chunk written to the hold address, followed by a 16-bit chunk written to the data address, gives an exact length for the chip-select low interval, and that length exposes both a missing hold and a missing idle gap. When five words are queued with the engine stopped, the drop of the fifth word shows up in the receive sequence.

// File: rtl/spi_vw_pkg.sv
package spi_vw_pkg;
   localparam int unsigned CHUNK_MAX = 24;
   localparam int unsigned LEN_W     = 5;

   // register offsets (bytes)
   localparam int unsigned OFS_CTRL0 = 'h00;
   localparam int unsigned OFS_CTRL1 = 'h04;
   localparam int unsigned OFS_STAT  = 'h08;
   localparam int unsigned OFS_DATA  = 'h20;
   localparam int unsigned OFS_HOLD  = 'h30;

   // control 0 bit positions
   localparam int unsigned C0_MSB_OUT  = 6;
   localparam int unsigned C0_CPOL     = 7;
   localparam int unsigned C0_OUT_RISE = 8;
   localparam int unsigned C0_FLUSH    = 9;
   localparam int unsigned C0_IN_RISE  = 10;
   localparam int unsigned C0_EN       = 11;
   localparam int unsigned C0_VARLEN   = 14;
   localparam int unsigned C0_DIV_LSB  = 20;

   // control 1 bit positions
   localparam int unsigned C1_MSB_IN   = 1;
   localparam int unsigned C1_IE_IDLE  = 6;
   localparam int unsigned C1_IE_TXE   = 7;

   typedef struct packed {
      logic                 last;
      logic [LEN_W-1:0]     nbits;
      logic [CHUNK_MAX-1:0] data;
   } tx_entry_t;
endpackage

// File: rtl/spi_vw_fifo.sv
module spi_vw_fifo #(
   parameter int unsigned WIDTH = 8,
   parameter int unsigned DEPTH = 4,
   localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
   localparam int unsigned LVL_W = $clog2(DEPTH + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             push,
   input  logic [WIDTH-1:0] din,
   input  logic             pop,
   output logic [WIDTH-1:0] dout,
   output logic [LVL_W-1:0] level,
   output logic             full,
   output logic             empty
);
   logic [WIDTH-1:0] mem_q [DEPTH];
   logic [PTR_W-1:0] rd_q, wr_q;
   logic [LVL_W-1:0] cnt_q;
   logic             do_push, do_pop;

   function automatic logic [PTR_W-1:0] nxt(input logic [PTR_W-1:0] p);
      return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
   endfunction

   assign full    = (cnt_q == LVL_W'(DEPTH));
   assign empty   = (cnt_q == '0);
   assign level   = cnt_q;
   assign dout    = mem_q[rd_q];
   assign do_push = push && !full && !clr;
   assign do_pop  = pop && !empty && !clr;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_q  <= '0;
         wr_q  <= '0;
         cnt_q <= '0;
      end else if (clr) begin
         rd_q  <= '0;
         wr_q  <= '0;
         cnt_q <= '0;
      end else begin
         if (do_push) wr_q <= nxt(wr_q);
         if (do_pop)  rd_q <= nxt(rd_q);
         case ({do_push, do_pop})
            2'b10:   cnt_q <= cnt_q + LVL_W'(1);
            2'b01:   cnt_q <= cnt_q - LVL_W'(1);
            default: cnt_q <= cnt_q;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (do_push) mem_q[wr_q] <= din;
   end
endmodule

// File: rtl/spi_vw_engine.sv
module spi_vw_engine import spi_vw_pkg::*; #(
   parameter int unsigned SPEED_W    = 12,
   parameter int unsigned GAP_CYCLES = 2,
   localparam int unsigned TICK_W    = LEN_W + 1,
   localparam int unsigned GAP_TICKS = 2 * GAP_CYCLES
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 enable,
   input  logic                 cpol,
   input  logic                 out_rise,
   input  logic                 in_rise,
   input  logic                 msb_out,
   input  logic                 msb_in,
   input  logic [SPEED_W-1:0]   speed,
   input  logic                 tx_valid,
   input  tx_entry_t            tx_entry,
   output logic                 tx_pop,
   output logic                 rx_push,
   output logic [CHUNK_MAX-1:0] rx_data,
   output logic                 busy,
   output logic                 sclk,
   output logic                 mosi,
   input  logic                 miso,
   output logic                 cs_n
);
   typedef enum logic [1:0] {ST_IDLE, ST_SHIFT, ST_GAP} st_t;

   st_t                  st_q;
   logic [SPEED_W-1:0]   div_q;
   logic [TICK_W-1:0]    tick_q;
   logic [LEN_W-1:0]     ncap_q, len_q, ncap_nx;
   logic [CHUNK_MAX-1:0] sh_q, rx_q, rx_nx;
   logic                 last_q, sclk_q, cs_q, busy_q;
   logic                 tick, rising, cap, launch, chunk_done, gap_done;

   always_comb begin
      tick       = (st_q != ST_IDLE) && (div_q == speed);
      rising     = !sclk_q;
      cap        = tick && (st_q == ST_SHIFT) && (rising == in_rise);
      ncap_nx    = ncap_q + LEN_W'(cap);
      launch     = tick && (st_q == ST_SHIFT) && (rising == out_rise) &&
                   (ncap_nx != '0) && (ncap_nx < len_q);
      rx_nx      = rx_q;
      if (cap) rx_nx = msb_in ? {rx_q[CHUNK_MAX-2:0], miso} : {miso, rx_q[CHUNK_MAX-1:1]};
      chunk_done = tick && (st_q == ST_SHIFT) && (tick_q == ({len_q, 1'b0} - TICK_W'(1)));
      gap_done   = tick && (st_q == ST_GAP) && (tick_q == TICK_W'(GAP_TICKS - 1));
   end

   assign rx_data = msb_in ? rx_nx : (rx_nx >> (CHUNK_MAX - len_q));
   assign rx_push = chunk_done;
   assign tx_pop  = enable && (st_q == ST_IDLE) && tx_valid;
   assign mosi    = msb_out ? sh_q[CHUNK_MAX-1] : sh_q[0];
   assign sclk    = sclk_q;
   assign cs_n    = cs_q;
   assign busy    = busy_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q <= ST_IDLE;  div_q <= '0;  tick_q <= '0;  ncap_q <= '0;
         len_q <= '0;  sh_q <= '0;  rx_q <= '0;  last_q <= 1'b0;
         sclk_q <= 1'b0;  cs_q <= 1'b1;  busy_q <= 1'b0;
      end else if (!enable) begin
         st_q   <= ST_IDLE;
         div_q  <= '0;
         sclk_q <= cpol;
         cs_q   <= 1'b1;
         busy_q <= 1'b0;
      end else if (st_q == ST_IDLE) begin
         sclk_q <= cpol;
         div_q  <= '0;
         if (tx_valid) begin
            st_q   <= ST_SHIFT;
            tick_q <= '0;
            ncap_q <= '0;
            rx_q   <= '0;
            len_q  <= tx_entry.nbits;
            last_q <= tx_entry.last;
            sh_q   <= msb_out ? tx_entry.data : (tx_entry.data >> (CHUNK_MAX - tx_entry.nbits));
            cs_q   <= 1'b0;
            busy_q <= 1'b1;
         end
      end else begin
         div_q <= tick ? '0 : div_q + SPEED_W'(1);
         if (tick) begin
            tick_q <= tick_q + TICK_W'(1);
            ncap_q <= ncap_nx;
            rx_q   <= rx_nx;
            if (st_q == ST_SHIFT) sclk_q <= !sclk_q;
            if (launch) sh_q <= msb_out ? (sh_q << 1) : (sh_q >> 1);
         end
         if (chunk_done) begin
            st_q   <= ST_GAP;
            tick_q <= '0;
         end
         if (gap_done) begin
            st_q   <= ST_IDLE;
            busy_q <= 1'b0;
            if (last_q) cs_q <= 1'b1;
         end
      end
   end
endmodule

// File: rtl/spi_vw_master.sv
module spi_vw_master import spi_vw_pkg::*; #(
   parameter int unsigned ADDR_W     = 6,
   parameter int unsigned DEPTH      = 4,
   parameter int unsigned SPEED_W    = 12,
   parameter int unsigned GAP_CYCLES = 2,
   localparam int unsigned LVL_W     = $clog2(DEPTH + 1),
   localparam int unsigned TXE_W     = $bits(tx_entry_t)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_wr,
   input  logic              bus_rd,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [31:0]       bus_wdata,
   output logic [31:0]       bus_rdata,
   output logic              spi_sclk,
   output logic              spi_mosi,
   input  logic              spi_miso,
   output logic              spi_cs_n,
   output logic              irq
);
   if (DEPTH < 2 || DEPTH > 255) begin : g_bad_depth
      $error("spi_vw_master: DEPTH must lie in 2..255");
   end
   if (SPEED_W < 1 || SPEED_W > 12) begin : g_bad_speed
      $error("spi_vw_master: SPEED_W must lie in 1..12");
   end
   if (ADDR_W < 6) begin : g_bad_addr
      $error("spi_vw_master: ADDR_W must be at least 6");
   end
   if (2 * GAP_CYCLES > 2 * CHUNK_MAX) begin : g_bad_gap
      $error("spi_vw_master: GAP_CYCLES too large for the tick counter");
   end

   logic [31:0]          ctrl0_q, ctrl1_q;
   logic                 sel_c0, sel_c1, sel_st, sel_dat, sel_hold;
   logic                 flush, tx_push, rx_pop, tx_pop, rx_push, eng_busy;
   logic                 tx_full, tx_empty, rx_full, rx_empty;
   logic [LVL_W-1:0]     tx_level, rx_level;
   logic [7:0]           tx_lvl8, rx_lvl8, cnt_fld;
   tx_entry_t            wr_entry, tx_head;
   logic [TXE_W-1:0]     tx_head_raw;
   logic [CHUNK_MAX-1:0] rx_head, rx_data;

   assign sel_c0   = (bus_addr == ADDR_W'(OFS_CTRL0));
   assign sel_c1   = (bus_addr == ADDR_W'(OFS_CTRL1));
   assign sel_st   = (bus_addr == ADDR_W'(OFS_STAT));
   assign sel_dat  = (bus_addr == ADDR_W'(OFS_DATA));
   assign sel_hold = (bus_addr == ADDR_W'(OFS_HOLD));
   assign flush    = bus_wr && sel_c0 && bus_wdata[C0_FLUSH];
   assign tx_push  = bus_wr && (sel_dat || sel_hold);
   assign rx_pop   = bus_rd && sel_dat;
   assign cnt_fld  = bus_wdata[31:24];

   always_comb begin
      wr_entry.last = sel_dat;
      wr_entry.data = bus_wdata[CHUNK_MAX-1:0];
      if (!ctrl0_q[C0_VARLEN])
         wr_entry.nbits = LEN_W'(8);
      else if (cnt_fld == 8'd0 || cnt_fld > 8'(CHUNK_MAX))
         wr_entry.nbits = LEN_W'(CHUNK_MAX);
      else
         wr_entry.nbits = cnt_fld[LEN_W-1:0];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl0_q <= '0;
         ctrl1_q <= '0;
      end else if (bus_wr) begin
         if (sel_c0) ctrl0_q <= bus_wdata & ~(32'd1 << C0_FLUSH);
         if (sel_c1) ctrl1_q <= bus_wdata & ((32'd1 << C1_IE_TXE) | (32'd1 << C1_IE_IDLE) | (32'd1 << C1_MSB_IN));
      end
   end

   spi_vw_fifo #(.WIDTH(TXE_W), .DEPTH(DEPTH)) i_txq (
      .clk(clk), .rst_n(rst_n), .clr(flush), .push(tx_push), .din(wr_entry),
      .pop(tx_pop), .dout(tx_head_raw), .level(tx_level), .full(tx_full), .empty(tx_empty));
   assign tx_head = tx_entry_t'(tx_head_raw);

   spi_vw_fifo #(.WIDTH(CHUNK_MAX), .DEPTH(DEPTH)) i_rxq (
      .clk(clk), .rst_n(rst_n), .clr(flush), .push(rx_push), .din(rx_data),
      .pop(rx_pop), .dout(rx_head), .level(rx_level), .full(rx_full), .empty(rx_empty));

   spi_vw_engine #(.SPEED_W(SPEED_W), .GAP_CYCLES(GAP_CYCLES)) i_eng (
      .clk(clk), .rst_n(rst_n), .enable(ctrl0_q[C0_EN]), .cpol(ctrl0_q[C0_CPOL]),
      .out_rise(ctrl0_q[C0_OUT_RISE]), .in_rise(ctrl0_q[C0_IN_RISE]),
      .msb_out(ctrl0_q[C0_MSB_OUT]), .msb_in(ctrl1_q[C1_MSB_IN]),
      .speed(ctrl0_q[C0_DIV_LSB +: SPEED_W]), .tx_valid(!tx_empty), .tx_entry(tx_head),
      .tx_pop(tx_pop), .rx_push(rx_push), .rx_data(rx_data), .busy(eng_busy),
      .sclk(spi_sclk), .mosi(spi_mosi), .miso(spi_miso), .cs_n(spi_cs_n));

   assign tx_lvl8 = 8'(tx_level);
   assign rx_lvl8 = 8'(rx_level);

   always_comb begin
      bus_rdata = '0;
      if (sel_c0)       bus_rdata = ctrl0_q;
      else if (sel_c1)  bus_rdata = ctrl1_q;
      else if (sel_st)  bus_rdata = {tx_lvl8, rx_lvl8, 5'd0, tx_full, tx_empty,
                                     rx_full, rx_empty, eng_busy, 6'd0};
      else if (sel_dat) bus_rdata = rx_empty ? 32'd0 : {{(32-CHUNK_MAX){1'b0}}, rx_head};
   end

   assign irq = (ctrl1_q[C1_IE_TXE] && tx_empty) || (ctrl1_q[C1_IE_IDLE] && !eng_busy);
endmodule

// File: rtl/spi_vw_master_chk.sv
module spi_vw_master_chk #(
   parameter int unsigned DEPTH = 4
) (
   input logic       clk,
   input logic       rst_n,
   input logic       spi_sclk,
   input logic       spi_cs_n,
   input logic       irq,
   input logic       cpol,
   input logic       busy,
   input logic       idle_en,
   input logic [7:0] tx_level
);
   AST_CS_FALL_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(spi_cs_n) |-> busy); // R5
   AST_CS_RISE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(spi_cs_n) |-> !busy); // R5
   AST_IDLE_CLK_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
      (spi_cs_n && $past(spi_cs_n) && $stable(cpol)) |-> (spi_sclk == cpol)); // R7
   AST_IDLE_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(busy) && idle_en) |-> irq); // R11
   AST_TX_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      tx_level <= 8'(DEPTH)); // R9
endmodule

bind spi_vw_master spi_vw_master_chk #(.DEPTH(DEPTH)) i_chk (
   .clk(clk), .rst_n(rst_n), .spi_sclk(spi_sclk), .spi_cs_n(spi_cs_n), .irq(irq),
   .cpol(ctrl0_q[7]), .busy(eng_busy), .idle_en(ctrl1_q[6]), .tx_level(tx_lvl8));

// File: tb/test_spi_vw_master.sv
module test_spi_vw_master;
   localparam logic [5:0] A_C0 = 6'h00, A_C1 = 6'h04, A_ST = 6'h08, A_DAT = 6'h20, A_HOLD = 6'h30;
   localparam logic [31:0] EN = 32'h800, VARW = 32'h4000, MSBO = 32'h40, INR = 32'h400,
                           OUTR = 32'h100, CPOL = 32'h80, MSBI = 32'h2;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_wr = 1'b0, bus_rd = 1'b0;
   logic [5:0]  bus_addr = 6'h08;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        spi_sclk, spi_mosi, spi_cs_n, irq;
   int          checks = 0, errors = 0;

   always #5 clk = ~clk;

   spi_vw_master i_spi_vw_master (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .spi_sclk(spi_sclk), .spi_mosi(spi_mosi),
      .spi_miso(spi_mosi), .spi_cs_n(spi_cs_n), .irq(irq));

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic bus_write(input logic [5:0] a, input logic [31:0] d);
      @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
      @(negedge clk); bus_wr = 1'b0; bus_addr = A_ST;
   endtask

   task automatic bus_read(input logic [5:0] a, output logic [31:0] d);
      @(negedge clk); bus_addr = a; bus_rd = 1'b1; #1 d = bus_rdata;
      @(negedge clk); bus_rd = 1'b0; bus_addr = A_ST;
   endtask

   task automatic cfg(input logic [31:0] c0, input logic [31:0] c1);
      bus_write(A_C1, c1);
      bus_write(A_C0, c0);
   endtask

   // watches one select-low interval: cycles low, cycles busy, first sclk half period
   task automatic watch(output int cs_cyc, output int busy_cyc, output int half);
      int edges = 0, t0 = 0;
      bit seen = 0;
      logic prev = spi_sclk;
      cs_cyc = 0; busy_cyc = 0; half = 0;
      for (int i = 0; i < 4000; i++) begin
         @(negedge clk); #1;
         if (!spi_cs_n) begin cs_cyc++; seen = 1; end
         else if (seen) break;
         if (bus_rdata[6]) busy_cyc++;
         if (spi_sclk !== prev) begin
            edges++;
            if (edges == 1) t0 = i;
            else if (edges == 2) half = i - t0;
            prev = spi_sclk;
         end
      end
   endtask

   task automatic t_reset();
      logic [31:0] d;
      bus_read(A_ST, d);
      check("R1 status", d, 32'h0000_0280);
      check("R1 cs_n", {31'd0, spi_cs_n}, 32'd1);
      check("R1 sclk", {31'd0, spi_sclk}, 32'd0);
      check("R1 irq", {31'd0, irq}, 32'd0);
   endtask

   task automatic t_chunk(input string tag, input logic [31:0] c0, input logic [31:0] c1,
                          input int spd, input logic [31:0] word, input int n,
                          input logic [31:0] exp);
      int cs_c, bz_c, hp;
      logic [31:0] d;
      cfg(c0 | (32'(spd) << 20), c1);
      bus_write(A_DAT, word);
      watch(cs_c, bz_c, hp);
      check({tag, " R6 select low cycles"}, cs_c, (2*n + 4) * (spd + 1));
      check({tag, " R2 half period"}, hp, spd + 1);
      bus_read(A_DAT, d);
      check({tag, " R4 rx data"}, d, exp);
      if (tag == "basic") begin
         check("basic R6 busy bit cycles", bz_c, (2*n + 4) * (spd + 1));
         bus_read(A_DAT, d);
         check("basic R4 empty read", d, 32'd0);
      end
   endtask

   task automatic t_hold();
      int cs_c, bz_c, hp;
      logic [31:0] d;
      cfg(VARW | MSBO | INR, MSBI);
      bus_write(A_HOLD, 32'h1812_3456);
      bus_write(A_DAT, 32'h10AB_CD00);
      cfg(EN | VARW | MSBO | INR, MSBI);
      watch(cs_c, bz_c, hp);
      check("R5 hold then end select low", cs_c, 89);
      check("R5 select released", {31'd0, spi_cs_n}, 32'd1);
      bus_read(A_DAT, d);
      check("R3 24-bit chunk", d, 32'h0012_3456);
      bus_read(A_DAT, d);
      check("R3 16-bit chunk", d, 32'h0000_ABCD);
   endtask

   task automatic t_cpol();
      cfg(EN | VARW | MSBO | CPOL | OUTR, MSBI);
      @(negedge clk);
      check("R7 idle level high", {31'd0, spi_sclk}, 32'd1);
   endtask

   task automatic t_fifo();
      logic [31:0] d;
      cfg(VARW | MSBO | INR, MSBI);
      for (int k = 1; k <= 5; k++) bus_write(A_DAT, 32'h0800_0000 | (32'(k * 'h11) << 16));
      bus_read(A_ST, d);
      check("R9 full tx status", d, 32'h0400_0480);
      cfg(EN | VARW | MSBO | INR, MSBI);
      repeat (200) @(negedge clk);
      bus_read(A_ST, d);
      check("R9 full rx status", d, 32'h0004_0300);
      for (int k = 1; k <= 4; k++) begin
         bus_read(A_DAT, d);
         check("R9 rx order, fifth dropped", d, 32'(k * 'h11));
      end
      bus_read(A_DAT, d);
      check("R4 read when empty", d, 32'd0);
   endtask

   task automatic t_flush();
      logic [31:0] d;
      cfg(VARW | MSBO | INR, MSBI);
      bus_write(A_HOLD, 32'h0811_0000);
      bus_write(A_DAT, 32'h0822_0000);
      repeat (50) @(negedge clk);
      check("R10 disabled no start", {31'd0, spi_cs_n}, 32'd1);
      bus_read(A_ST, d);
      check("R10 queued level", d, 32'h0200_0080);
      bus_write(A_C1, 32'd0);
      bus_write(A_C0, 32'h200);
      bus_read(A_ST, d);
      check("R10 flushed status", d, 32'h0000_0280);
      bus_read(A_C0, d);
      check("R10 control readback", d, 32'd0);
   endtask

   task automatic t_irq();
      check("R11 irq off", {31'd0, irq}, 32'd0);
      bus_write(A_C1, 32'h80);
      check("R11 tx empty irq", {31'd0, irq}, 32'd1);
      bus_write(A_DAT, 32'h0855_0000);
      check("R11 tx not empty", {31'd0, irq}, 32'd0);
      bus_write(A_C1, 32'h42);
      check("R11 idle irq", {31'd0, irq}, 32'd1);
      bus_write(A_C0, EN | VARW | MSBO | INR);
      repeat (5) @(negedge clk);
      check("R11 busy masks idle irq", {31'd0, irq}, 32'd0);
      repeat (40) @(negedge clk);
      check("R11 idle irq after chunk", {31'd0, irq}, 32'd1);
      bus_write(A_C1, 32'd0);
      bus_write(A_C0, 32'h200);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      errors++;
      $display("FAIL watchdog (all requirements) actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_chunk("basic", EN | VARW | MSBO | INR, MSBI, 1, 32'h08A5_0000, 8, 32'hA5);
      t_hold();
      t_cpol();
      t_chunk("cpol1 launch rise", EN | VARW | MSBO | CPOL | OUTR, MSBI, 0, 32'h10C3_5A00, 16, 32'hC35A);
      t_chunk("same edge R7", EN | VARW | MSBO | OUTR | INR, MSBI, 0, 32'h083C_0000, 8, 32'h3C);
      t_chunk("both falling R7", EN | VARW | MSBO, MSBI, 2, 32'h0896_0000, 8, 32'h96);
      t_chunk("lsb both R8", EN | VARW | INR, 32'd0, 0, 32'h1012_3400, 16, 32'h1234);
      t_chunk("mixed order R8", EN | VARW | MSBO | INR, 32'd0, 0, 32'h0801_0000, 8, 32'h80);
      t_chunk("fixed width R3", EN | MSBO | INR, MSBI, 3, 32'h00C3_0000, 8, 32'hC3);
      t_fifo();
      t_flush();
      t_irq();
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule